// File: doc/BRIEF.md
# Flash Command Interface Model

A synthesizable, cycle-based model of a byte-wide parallel flash device's command logic. It is meant to sit in a testbench as the target of a flash controller. It holds a small byte array that is split into eight sectors. All control and bus inputs are sampled on a system clock. The block follows active-low chip-enable, output-enable and write-enable strobes, a 17-bit address and an 8-bit data bus, and it decodes the multi-write unlock sequences that select programming, sector erase, identification and reset.

Each program or erase runs for a parameterised number of clock cycles. For that whole time, read accesses return a status byte instead of array data. The status byte has a polling bit, a toggle bit, a failure flag and an erase-in-progress flag. The bidirectional bus is split into `data_i` and `data_o`. `data_oe_o` marks when the model drives the bus.

Top module: `flash_cmd_model`

## Requirements
- R1: `data_oe_o` is 1 only while `ce_ni`=0, `oe_ni`=0 and `we_ni`=1. With `ce_ni`=1 the block is in standby and never drives the bus.
- R2: The write strobe is the OR of `ce_ni` and `we_ni`. The address is taken on its falling edge and the data on its rising edge, so the address may change before the strobe rises.
- R3: After reset every byte holds 0xFF and the block is in read mode, where a read returns the byte at array index {addr[16:14], addr[SECT_AW-1:0]}. Address bits between those two fields are ignored.
- R4: Writes of 0xAA to 0x05555, 0x55 to 0x02AAA and 0xA0 to 0x05555, followed by a write of PD to PA, store (old AND PD) at PA once BUSY_CYC cycles have passed.
- R5: Writes of 0xAA/0x05555, 0x55/0x02AAA, 0x80/0x05555, 0xAA/0x05555, 0x55/0x02AAA and then 0x30 to any address SA set every byte of sector SA[16:14] to 0xFF after BUSY_CYC cycles. Other sectors keep their contents.
- R6: While busy, a read returns status. Bit 7 is the complement of bit 7 of the programmed data, or 0 during an erase. Bit 3 is 1 during an erase and 0 during a program. Bits 4, 2, 1 and 0 read 0.
- R7: Status bit 6 inverts at the start of each read access during an operation. The first status read after the operation starts shows 1.
- R8: Status bit 5 reads 1 when a program tries to turn a 0 bit into 1. The stored result is still old AND PD.
- R9: Writes issued while an operation is busy are ignored. They neither stop the operation nor change the array.
- R10: The two unlock writes followed by 0x90 to 0x05555 enter identification mode. There, a read with addr[7:0]=0x00 returns 0x01, addr[7:0]=0x01 returns 0x20, and any other offset returns 0x00. Any write other than a fresh 0xAA/0x05555 (for example 0xF0) returns the block to read mode.
- R11: A write that breaks an expected sequence returns the block to read mode and changes no memory.
- R12: When an operation ends, the block is back in read mode. A read of an erased byte then returns 0xFF, with bit 7 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | 17 | Byte address |
| data_i | input | 8 | Write data from the bus |
| data_o | output | 8 | Read data or status |
| data_oe_o | output | 1 | Block drives the data bus |

## Verification
Command decoding and the embedded-operation timer are active together: a write strobe can be decoded in a cycle where the busy counter is still running. The bench provokes this by sending a direct data write and a 0xF0 reset in the middle of a program operation. It then expects the next read to still return the busy status pattern, with the toggle bit in its first-read phase, and the final byte to hold only the original program data. A second overlap is a status read that starts while the operation is running. The bench judges it by checking that consecutive reads show bit 6 alternating, and that the first plain read after the wait returns array data.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int ADDR_W = 17;
  localparam int DATA_W = 8;
  localparam int SSEL_W = 3;

  typedef enum logic [3:0] {
    S_READ, S_U1, S_U2, S_PROG, S_ES, S_EU1, S_EU2, S_ID, S_BUSY
  } mode_e;

  localparam logic [ADDR_W-1:0] UL_ADDR1 = 17'h05555;
  localparam logic [ADDR_W-1:0] UL_ADDR2 = 17'h02AAA;
  localparam logic [DATA_W-1:0] UL_CODE1 = 8'hAA;
  localparam logic [DATA_W-1:0] UL_CODE2 = 8'h55;
  localparam logic [DATA_W-1:0] CMD_PROG = 8'hA0;
  localparam logic [DATA_W-1:0] CMD_ERS  = 8'h80;
  localparam logic [DATA_W-1:0] CMD_ID   = 8'h90;
  localparam logic [DATA_W-1:0] CMD_SECT = 8'h30;
  localparam logic [DATA_W-1:0] ID_MFR   = 8'h01;
  localparam logic [DATA_W-1:0] ID_DEV   = 8'h20;
endpackage

// File: rtl/flash_bus_edge.sv
module flash_bus_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  input  logic we_ni,
  output logic wr_fall_o,
  output logic wr_rise_o,
  output logic rd_act_o,
  output logic rd_start_o
);
  logic wr_n, wr_n_q, rd_q;

  assign wr_n     = ce_ni | we_ni;
  assign rd_act_o = ~ce_ni & ~oe_ni & we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_n_q <= 1'b1;
      rd_q   <= 1'b0;
    end else begin
      wr_n_q <= wr_n;
      rd_q   <= rd_act_o;
    end
  end

  assign wr_fall_o  = wr_n_q & ~wr_n;
  assign wr_rise_o  = ~wr_n_q & wr_n;
  assign rd_start_o = rd_act_o & ~rd_q;
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int SECT_AW = 5,
  localparam int IDX_W  = flash_cmd_pkg::SSEL_W + SECT_AW,
  localparam int DEPTH  = 1 << IDX_W,
  localparam int SECT_N = 1 << SECT_AW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prog_we_i,
  input  logic [IDX_W-1:0] prog_idx_i,
  input  logic [7:0]       prog_data_i,
  input  logic             erase_we_i,
  input  logic [2:0]       erase_sect_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_byte_o,
  input  logic [IDX_W-1:0] chk_idx_i,
  output logic [7:0]       chk_byte_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (prog_we_i) begin
      mem_q[prog_idx_i] <= mem_q[prog_idx_i] & prog_data_i;  // only clears bits
    end else if (erase_we_i) begin
      for (int i = 0; i < SECT_N; i++) mem_q[{erase_sect_i, SECT_AW'(i)}] <= 8'hFF;
    end
  end

  assign rd_byte_o  = mem_q[rd_idx_i];
  assign chk_byte_o = mem_q[chk_idx_i];
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int SECT_AW  = 5,
  parameter int BUSY_CYC = 64,
  localparam int IDX_W   = SSEL_W + SECT_AW,
  localparam int CNT_W   = $clog2(BUSY_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_fall_i,
  input  logic              wr_rise_i,
  input  logic              rd_start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [7:0]        chk_byte_i,
  output logic [IDX_W-1:0]  chk_idx_o,
  output mode_e             mode_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              op_erase_o,
  output logic [IDX_W-1:0]  prog_idx_o,
  output logic [7:0]        prog_data_o,
  output logic [2:0]        sect_o,
  output logic              fail_o,
  output logic              tgl_o
);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYC - 1);

  mode_e             mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  pa_q;
  logic [7:0]        pd_q;
  logic [2:0]        sect_q;
  logic              erase_q, fail_q, tgl_q;
  logic              is_ul1, is_ul2, at_a1;

  assign at_a1  = addr_q == UL_ADDR1;
  assign is_ul1 = at_a1 && data_i == UL_CODE1;
  assign is_ul2 = addr_q == UL_ADDR2 && data_i == UL_CODE2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= S_READ;
      addr_q  <= '0;
      cnt_q   <= '0;
      pa_q    <= '0;
      pd_q    <= '0;
      sect_q  <= '0;
      erase_q <= 1'b0;
      fail_q  <= 1'b0;
      tgl_q   <= 1'b0;
    end else begin
      if (wr_fall_i) addr_q <= addr_i;
      if (mode_q == S_BUSY) begin
        if (rd_start_i) tgl_q <= ~tgl_q;
        if (cnt_q == '0) mode_q <= S_READ;
        else             cnt_q  <= cnt_q - 1'b1;
      end else if (wr_rise_i) begin
        case (mode_q)
          S_READ, S_ID: mode_q <= is_ul1 ? S_U1 : S_READ;
          S_U1:         mode_q <= is_ul2 ? S_U2 : S_READ;
          S_U2: begin
            if (at_a1 && data_i == CMD_PROG)     mode_q <= S_PROG;
            else if (at_a1 && data_i == CMD_ERS) mode_q <= S_ES;
            else if (at_a1 && data_i == CMD_ID)  mode_q <= S_ID;
            else                                 mode_q <= S_READ;
          end
          S_PROG: begin
            pa_q    <= chk_idx_o;
            pd_q    <= data_i;
            erase_q <= 1'b0;
            fail_q  <= |(data_i & ~chk_byte_i);  // attempt to raise a cleared bit
            cnt_q   <= CNT_LOAD;
            tgl_q   <= 1'b0;
            mode_q  <= S_BUSY;
          end
          S_ES:  mode_q <= is_ul1 ? S_EU1 : S_READ;
          S_EU1: mode_q <= is_ul2 ? S_EU2 : S_READ;
          S_EU2: begin
            if (data_i == CMD_SECT) begin
              sect_q  <= addr_q[16:14];
              erase_q <= 1'b1;
              fail_q  <= 1'b0;
              cnt_q   <= CNT_LOAD;
              tgl_q   <= 1'b0;
              mode_q  <= S_BUSY;
            end else begin
              mode_q <= S_READ;
            end
          end
          default: mode_q <= S_READ;
        endcase
      end
    end
  end

  assign chk_idx_o   = {addr_q[16:14], addr_q[SECT_AW-1:0]};
  assign mode_o      = mode_q;
  assign busy_o      = mode_q == S_BUSY;
  assign done_o      = busy_o && cnt_q == '0;
  assign op_erase_o  = erase_q;
  assign prog_idx_o  = pa_q;
  assign prog_data_o = pd_q;
  assign sect_o      = sect_q;
  assign fail_o      = fail_q;
  assign tgl_o       = tgl_q;
endmodule

// File: rtl/flash_cmd_model.sv
module flash_cmd_model
  import flash_cmd_pkg::*;
#(
  parameter int SECT_AW  = 5,
  parameter int BUSY_CYC = 64,
  localparam int IDX_W   = SSEL_W + SECT_AW
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ce_ni,
  input  logic        oe_ni,
  input  logic        we_ni,
  input  logic [16:0] addr_i,
  input  logic [7:0]  data_i,
  output logic [7:0]  data_o,
  output logic        data_oe_o
);
  logic             wr_fall, wr_rise, rd_act, rd_start;
  logic             busy, done, op_erase, fail, tgl;
  mode_e            mode;
  logic [IDX_W-1:0] chk_idx, prog_idx, rd_idx;
  logic [7:0]       chk_byte, rd_byte, prog_data, status, id_byte;
  logic [2:0]       sect;

  flash_bus_edge i_edge (
    .clk_i, .rst_ni, .ce_ni, .oe_ni, .we_ni,
    .wr_fall_o(wr_fall), .wr_rise_o(wr_rise),
    .rd_act_o(rd_act), .rd_start_o(rd_start)
  );

  flash_cmd_fsm #(.SECT_AW(SECT_AW), .BUSY_CYC(BUSY_CYC)) i_fsm (
    .clk_i, .rst_ni,
    .wr_fall_i(wr_fall), .wr_rise_i(wr_rise), .rd_start_i(rd_start),
    .addr_i, .data_i,
    .chk_byte_i(chk_byte), .chk_idx_o(chk_idx),
    .mode_o(mode), .busy_o(busy), .done_o(done), .op_erase_o(op_erase),
    .prog_idx_o(prog_idx), .prog_data_o(prog_data), .sect_o(sect),
    .fail_o(fail), .tgl_o(tgl)
  );

  assign rd_idx = {addr_i[16:14], addr_i[SECT_AW-1:0]};

  flash_array #(.SECT_AW(SECT_AW)) i_array (
    .clk_i, .rst_ni,
    .prog_we_i(done & ~op_erase), .prog_idx_i(prog_idx), .prog_data_i(prog_data),
    .erase_we_i(done & op_erase), .erase_sect_i(sect),
    .rd_idx_i(rd_idx), .rd_byte_o(rd_byte),
    .chk_idx_i(chk_idx), .chk_byte_o(chk_byte)
  );

  assign status = {(op_erase ? 1'b0 : ~prog_data[7]), tgl, fail, 1'b0, op_erase, 3'b000};

  always_comb begin
    if (addr_i[7:0] == 8'h00)      id_byte = ID_MFR;
    else if (addr_i[7:0] == 8'h01) id_byte = ID_DEV;
    else                           id_byte = 8'h00;
  end

  always_comb begin
    if (!rd_act)            data_o = 8'h00;
    else if (busy)          data_o = status;
    else if (mode == S_ID)  data_o = id_byte;
    else                    data_o = rd_byte;
  end

  assign data_oe_o = rd_act;
endmodule

// File: rtl/flash_cmd_model_chk.sv
module flash_cmd_model_chk
  import flash_cmd_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ce_ni,
  input logic       data_oe_o,
  input logic [7:0] data_o,
  input logic       busy,
  input logic       done,
  input logic       op_erase,
  input logic       tgl,
  input logic       rd_start,
  input logic       rd_act,
  input logic       wr_rise,
  input mode_e      mode
);
  AST_STANDBY_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> !data_oe_o);  // R1

  AST_BUSY_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(wr_rise));  // R4

  AST_ERASE_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && op_erase && rd_act) |-> (data_o[3] && !data_o[7]));  // R6

  AST_TOGGLE_PER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && rd_start && !done) |=> (tgl != $past(tgl)));  // R7

  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done) |=> busy);  // R9

  AST_DONE_TO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> (mode == S_READ));  // R12
endmodule

bind flash_cmd_model flash_cmd_model_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .data_oe_o(data_oe_o),
  .data_o(data_o), .busy(busy), .done(done), .op_erase(op_erase), .tgl(tgl),
  .rd_start(rd_start), .rd_act(rd_act), .wr_rise(wr_rise), .mode(mode)
);

// File: tb/test_flash_cmd_model.sv
module test_flash_cmd_model;
  localparam int SECT_AW  = 5;
  localparam int BUSY_CYC = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        doe;

  int n_chk = 0, n_err = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_v;
  event       smp_ev;

  always #10 clk = ~clk;

  flash_cmd_model #(.SECT_AW(SECT_AW), .BUSY_CYC(BUSY_CYC)) i_flash_cmd_model (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(doe)
  );

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: pops the expected item for every completed read
  initial forever begin
    @(smp_ev);
    check(tag_q.pop_front(), got_v, exp_q.pop_front());
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  task automatic wr(logic [16:0] a, logic [7:0] d);
    @(negedge clk); addr = a; din = d; ce_n = 0; we_n = 0;
    @(negedge clk);
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1;
  endtask

  // address changes before the strobe rises, data arrives late
  task automatic wr_skew(logic [16:0] a, logic [7:0] d);
    @(negedge clk); addr = a; din = ~d; ce_n = 0; we_n = 0;
    @(negedge clk); addr = a ^ 17'h00013; din = d;
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1;
  endtask

  // driver: queues the expected value and hands the sample to the monitor
  task automatic rd(logic [16:0] a, logic [7:0] exp, string tag);
    @(negedge clk); addr = a; ce_n = 0; oe_n = 0;
    @(negedge clk);
    @(negedge clk);
    check({tag, " oe"}, {7'd0, doe}, 8'h01);
    exp_q.push_back(exp); tag_q.push_back(tag);
    got_v = dout; ->smp_ev;
    oe_n = 1; ce_n = 1;
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(17'h05555, 8'hAA);
    wr(17'h02AAA, 8'h55);
  endtask

  task automatic prog(logic [16:0] a, logic [7:0] d);
    unlock(); wr(17'h05555, 8'hA0); wr(a, d);
  endtask

  task automatic wait_op();
    repeat (BUSY_CYC + 10) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle", {7'd0, doe}, 8'h00);
    oe_n = 0; @(negedge clk);
    check("R1 standby", {7'd0, doe}, 8'h00);
    oe_n = 1;
    rd(17'h00010, 8'hFF, "R3 reset");

    // program with skewed address/data, status during busy
    unlock(); wr(17'h05555, 8'hA0); wr_skew(17'h00010, 8'h5A);
    rd(17'h00010, 8'hC0, "R6 R7 status1");
    rd(17'h00010, 8'h80, "R7 status2");
    wait_op();
    rd(17'h00010, 8'h5A, "R2 R4 R12 prog");
    rd(17'h00030, 8'h5A, "R3 alias");

    // failing program: 0->1 attempt
    prog(17'h00010, 8'hFF);
    rd(17'h00010, 8'h60, "R8 fail status");
    wait_op();
    rd(17'h00010, 8'h5A, "R8 result");
    prog(17'h00010, 8'h0F);
    wait_op();
    rd(17'h00010, 8'h0A, "R4 and");

    prog(17'h1C003, 8'h81); wait_op();
    prog(17'h04010, 8'h11); wait_op();
    rd(17'h1C003, 8'h81, "R4 sect7");

    // identification mode
    unlock(); wr(17'h05555, 8'h90);
    rd(17'h00000, 8'h01, "R10 mfr");
    rd(17'h00001, 8'h20, "R10 dev");
    rd(17'h14001, 8'h20, "R10 dev sect5");
    rd(17'h00002, 8'h00, "R10 other");
    wr(17'h00000, 8'hF0);
    rd(17'h00010, 8'h0A, "R10 exit reset");
    unlock(); wr(17'h05555, 8'h90);
    wr(17'h00123, 8'h00);
    rd(17'h00001, 8'hFF, "R10 exit other");

    // broken sequences
    unlock(); wr(17'h05555, 8'h77); wr(17'h1C003, 8'h00);
    rd(17'h1C003, 8'h81, "R11 bad cmd");
    wr(17'h05555, 8'hAA); wr(17'h01234, 8'h55); wr(17'h05555, 8'hA0); wr(17'h1C003, 8'h00);
    rd(17'h1C003, 8'h81, "R11 bad unlock");

    // writes during busy are ignored
    prog(17'h1C004, 8'h3C);
    wr(17'h1C004, 8'h00);
    wr(17'h05555, 8'hF0);
    rd(17'h1C004, 8'hC0, "R9 still busy");
    wait_op();
    rd(17'h1C004, 8'h3C, "R9 data");

    // sector erase
    unlock(); wr(17'h05555, 8'h80); unlock(); wr(17'h00000, 8'h30);
    rd(17'h00010, 8'h48, "R5 R6 erase status1");
    rd(17'h00010, 8'h08, "R7 erase status2");
    wait_op();
    rd(17'h00010, 8'hFF, "R5 R12 erased");
    rd(17'h04010, 8'h11, "R5 sect1 kept");
    rd(17'h1C003, 8'h81, "R5 sect7 kept");

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule